// File: doc/BRIEF.md
# Paged Address Translator with Translation Cache

This block turns logical addresses from a requester into physical addresses for a small paged memory. The upper bits of a logical address select a page and the lower bits give an offset inside it. The translator looks up the page in a small, fully associative translation cache. On a hit, the physical address is the cached frame number placed above the unchanged offset, and the block issues one data access. On a miss, the block first reads the page-table entry through the same single memory port, refills the cache, and then issues the data access.

A page-table entry for page `p` is read from memory at `pt_base + p`. If that entry is marked not present, the request ends with a fault response. In that case there is no data access and no refill. Pulsing `flush` drops every cached translation. The block accepts a new request only while it is idle.

The default build is byte addressed: 8-bit addresses, 16 frames of 16 bytes. Setting `ADDR_W=6, OFF_W=2` gives the word-addressed variant, where each address names a 4-byte word.

Top module: `paged_xlate`

## Requirements
- R1: In the default build (ADDR_W=8, OFF_W=4), the physical address equals frame*16 + (logical address mod 16). Example: logical 24 with page 1 mapped to frame 6 gives 104.
- R2: With ADDR_W=6 and OFF_W=2, the page is address bits [5:2] and the offset is bits [1:0]. Example: logical 13 with page 3 mapped to frame 9 gives physical 37.
- R3: A request whose page hits a valid cache entry makes exactly one memory access, and that access is the data access at the translated address. A hit keeps using the cached frame even after the page-table entry in memory changes, until a flush.
- R4: A miss makes exactly two memory accesses. The first is a read of the page-table entry at (pt_base + page) mod 2^ADDR_W. The second is the data access. In a page-table entry, bit DATA_W-1 is the present flag and bits [ADDR_W-OFF_W-1:0] hold the frame.
- R5: If the fetched page-table entry has its present bit at 0, the response has `rsp_fault`=1 after that single access. No data access is made and no refill happens, so repeating the same request walks the table again.
- R6: Only valid entries can hit. After reset, the first request to any page is a miss, and at most one entry matches any page.
- R7: A one-cycle `flush` clears every valid bit, so each page is a miss on its next request.
- R8: A refill writes the lowest-indexed invalid entry. If every entry is valid, it replaces the entry at a round-robin pointer. That pointer starts at 0 after reset, advances (wrapping at TLB_N) only on such a replacement, and is not changed by flush.
- R9: `req_ready` is high exactly when the block is idle. It is high out of reset, it is low from the cycle after acceptance until the response, and `rsp_valid` is low after reset.
- R10: `rsp_valid` is a one-cycle pulse. A read returns the memory word at the physical address. A write stores `req_wdata` there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| pt_base | input | ADDR_W | Address of the entry for page 0 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Logical address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Page not present |
| rsp_paddr | output | ADDR_W | Translated address (0 on fault) |
| rsp_rdata | output | DATA_W | Read data |
| mem_req | output | 1 | Memory access held until acknowledged |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Access done; read data valid in this cycle |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The hardest condition to reach is replacement once the cache is full: every entry must be valid and the round-robin pointer must sit at a known place. A flush also leaves that pointer where it was. The stimulus gets there with a directed pass over eight distinct pages followed by a ninth. It then runs a long seeded random mix of reads, writes, flushes and page-table rewrites. Throughout, a bench model of the cache predicts hit or miss, which shows up at the ports as the number of memory accesses and the address of each one.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  typedef enum logic [1:0] {
    PX_IDLE = 2'd0,
    PX_WALK = 2'd1,
    PX_DATA = 2'd2
  } px_state_e;
endpackage

// File: rtl/pxl_victim.sv
module pxl_victim #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     valid_vec,
  input  logic [IDX_W-1:0] rr_q,
  output logic [IDX_W-1:0] vic_idx,
  output logic             any_free
);
  logic [IDX_W-1:0] free_idx;

  // lowest invalid slot wins; scan from the top so the lowest overwrites last
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign vic_idx = any_free ? free_idx : rr_q;
endmodule

// File: rtl/pxl_tlb.sv
module pxl_tlb #(
  parameter int N      = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [PAGE_W-1:0] look_page,
  output logic              look_hit,
  output logic [PAGE_W-1:0] look_frame,
  output logic [N-1:0]      hit_vec,
  output logic [N-1:0]      valid_vec,
  output logic              any_free,
  input  logic              refill_en,
  input  logic [PAGE_W-1:0] refill_page,
  input  logic [PAGE_W-1:0] refill_frame
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [PAGE_W-1:0] tag_q [N];
  logic [PAGE_W-1:0] frm_q [N];
  logic [N-1:0]      vld_q;
  logic [IDX_W-1:0]  rr_q;
  logic [IDX_W-1:0]  vic_idx;

  // parallel compare of every slot
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == look_page);
  end

  always_comb begin
    look_frame = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) look_frame = look_frame | frm_q[i];
    end
  end

  assign look_hit  = |hit_vec;
  assign valid_vec = vld_q;

  pxl_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
    .valid_vec (vld_q),
    .rr_q      (rr_q),
    .vic_idx   (vic_idx),
    .any_free  (any_free)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else if (refill_en) begin
      vld_q[vic_idx] <= 1'b1;
      if (!any_free) begin
        rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (refill_en) begin
      tag_q[vic_idx] <= refill_page;
      frm_q[vic_idx] <= refill_frame;
    end
  end
endmodule

// File: rtl/pxl_ctrl.sv
module pxl_ctrl
  import pxl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_we,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [ADDR_W-1:0]        pt_base,
  input  logic                     look_hit,
  input  logic [ADDR_W-OFF_W-1:0]  look_frame,
  input  logic                     mem_ack,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic                     req_ready,
  output logic                     accept_ev,
  output logic                     in_walk,
  output logic                     walk_fault_ev,
  output logic                     refill_en,
  output logic [ADDR_W-OFF_W-1:0]  refill_page,
  output logic [ADDR_W-OFF_W-1:0]  refill_frame,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic                     rsp_valid,
  output logic                     rsp_fault,
  output logic [ADDR_W-1:0]        rsp_paddr,
  output logic [DATA_W-1:0]        rsp_rdata
);
  localparam int PAGE_W = ADDR_W - OFF_W;

  function automatic logic [ADDR_W-1:0] join_phys(input logic [PAGE_W-1:0] fr,
                                                  input logic [OFF_W-1:0]  off);
    return {fr, off};
  endfunction

  function automatic logic [ADDR_W-1:0] pte_loc(input logic [ADDR_W-1:0] base,
                                                input logic [PAGE_W-1:0] pg);
    return base + ADDR_W'(pg);
  endfunction

  px_state_e          state_q;
  logic [PAGE_W-1:0]  page_q, frame_q;
  logic [OFF_W-1:0]   off_q;
  logic               we_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               rsp_valid_q, rsp_fault_q;
  logic [ADDR_W-1:0]  rsp_paddr_q;
  logic [DATA_W-1:0]  rsp_rdata_q;
  logic               pte_present;
  logic [PAGE_W-1:0]  pte_frame;
  logic [ADDR_W-1:0]  data_addr;

  assign pte_present   = mem_rdata[DATA_W-1];
  assign pte_frame     = mem_rdata[PAGE_W-1:0];
  assign data_addr     = join_phys(frame_q, off_q);

  assign req_ready     = (state_q == PX_IDLE);
  assign accept_ev     = req_ready && req_valid;
  assign in_walk       = (state_q == PX_WALK);
  assign refill_en     = in_walk && mem_ack && pte_present;
  assign walk_fault_ev = in_walk && mem_ack && !pte_present;
  assign refill_page   = page_q;
  assign refill_frame  = pte_frame;

  assign mem_req   = (state_q != PX_IDLE);
  assign mem_we    = (state_q == PX_DATA) && we_q;
  assign mem_addr  = in_walk ? pte_loc(pt_base, page_q) : data_addr;
  assign mem_wdata = wdata_q;

  assign rsp_valid = rsp_valid_q;
  assign rsp_fault = rsp_fault_q;
  assign rsp_paddr = rsp_paddr_q;
  assign rsp_rdata = rsp_rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= PX_IDLE;
      page_q      <= '0;
      off_q       <= '0;
      frame_q     <= '0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_paddr_q <= '0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        PX_IDLE: begin
          if (req_valid) begin
            page_q  <= req_addr[ADDR_W-1:OFF_W];
            off_q   <= req_addr[OFF_W-1:0];
            we_q    <= req_we;
            wdata_q <= req_wdata;
            if (look_hit) begin
              frame_q <= look_frame;
              state_q <= PX_DATA;
            end else begin
              state_q <= PX_WALK;
            end
          end
        end
        PX_WALK: begin
          if (mem_ack) begin
            if (pte_present) begin
              frame_q <= pte_frame;
              state_q <= PX_DATA;
            end else begin
              state_q     <= PX_IDLE;
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b1;
              rsp_paddr_q <= '0;
            end
          end
        end
        PX_DATA: begin
          if (mem_ack) begin
            state_q     <= PX_IDLE;
            rsp_valid_q <= 1'b1;
            rsp_fault_q <= 1'b0;
            rsp_paddr_q <= data_addr;
            rsp_rdata_q <= mem_rdata;
          end
        end
        default: state_q <= PX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/paged_xlate.sv
module paged_xlate #(
  parameter int TLB_N  = 8,
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-1:0] pt_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic              look_hit;
  logic [PAGE_W-1:0] look_frame;
  logic [TLB_N-1:0]  hit_vec, valid_vec;
  logic              any_free;
  logic              accept_ev, in_walk, walk_fault_ev, refill_en;
  logic [PAGE_W-1:0] refill_page, refill_frame;

  pxl_tlb #(.N(TLB_N), .PAGE_W(PAGE_W)) u_tlb (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .look_page    (req_addr[ADDR_W-1:OFF_W]),
    .look_hit     (look_hit),
    .look_frame   (look_frame),
    .hit_vec      (hit_vec),
    .valid_vec    (valid_vec),
    .any_free     (any_free),
    .refill_en    (refill_en),
    .refill_page  (refill_page),
    .refill_frame (refill_frame)
  );

  pxl_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_we        (req_we),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .pt_base       (pt_base),
    .look_hit      (look_hit),
    .look_frame    (look_frame),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .req_ready     (req_ready),
    .accept_ev     (accept_ev),
    .in_walk       (in_walk),
    .walk_fault_ev (walk_fault_ev),
    .refill_en     (refill_en),
    .refill_page   (refill_page),
    .refill_frame  (refill_frame),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_paddr     (rsp_paddr),
    .rsp_rdata     (rsp_rdata)
  );
endmodule

// File: rtl/pxl_chk.sv
module pxl_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         flush,
  input logic         req_ready,
  input logic         accept_ev,
  input logic         look_hit,
  input logic         in_walk,
  input logic         walk_fault_ev,
  input logic         refill_en,
  input logic         any_free,
  input logic         mem_req,
  input logic         rsp_valid,
  input logic         rsp_fault,
  input logic [N-1:0] hit_vec,
  input logic [N-1:0] valid_vec
);
  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> !req_ready);

  // R3
  hit_goes_to_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ev && look_hit) |=> (mem_req && !in_walk));

  // R4
  miss_walks_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ev && !look_hit) |=> (mem_req && in_walk));

  // R4
  refill_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_en |=> (mem_req && !in_walk));

  // R5
  fault_no_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_fault_ev |-> !refill_en);

  // R5
  fault_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_fault_ev |=> (rsp_valid && rsp_fault && !mem_req));

  // R6
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R7
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));

  // R8
  free_slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_en && any_free && !flush) |=>
      ($countones(valid_vec) == $countones($past(valid_vec)) + 1));

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind paged_xlate pxl_chk #(.N(TLB_N)) u_pxl_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush         (flush),
  .req_ready     (req_ready),
  .accept_ev     (accept_ev),
  .look_hit      (look_hit),
  .in_walk       (in_walk),
  .walk_fault_ev (walk_fault_ev),
  .refill_en     (refill_en),
  .any_free      (any_free),
  .mem_req       (mem_req),
  .rsp_valid     (rsp_valid),
  .rsp_fault     (rsp_fault),
  .hit_vec       (hit_vec),
  .valid_vec     (valid_vec)
);

// File: tb/tb_paged_xlate.sv
`timescale 1ns/1ps
module tb_paged_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  // ---------------- byte-addressed instance ----------------
  logic       flush = 1'b0;
  logic [7:0] pt_base = 8'hE0;
  logic       req_valid = 1'b0, req_we = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic       req_ready, rsp_valid, rsp_fault;
  logic [7:0] rsp_paddr, rsp_rdata;
  logic       mreq, mwe, mack;
  logic [7:0] maddr, mwd, mrd;

  paged_xlate dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .rsp_rdata(rsp_rdata), .mem_req(mreq), .mem_we(mwe), .mem_addr(maddr),
    .mem_wdata(mwd), .mem_ack(mack), .mem_rdata(mrd)
  );

  logic [7:0] mem [256];
  int acc_total = 0;
  int hist0 = 0, hist1 = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mack <= 1'b0;
    end else begin
      mack <= mreq && !mack;
      if (mreq && !mack) begin
        mrd <= mem[maddr];
        if (mwe) mem[maddr] <= mwd;
        acc_total <= acc_total + 1;
        hist1 <= hist0;
        hist0 <= int'(maddr);
      end
    end
  end

  // ---------------- word-addressed instance ----------------
  logic       req_valid_w = 1'b0;
  logic [5:0] req_addr_w = '0;
  logic       req_ready_w, rsp_valid_w, rsp_fault_w;
  logic [5:0] rsp_paddr_w;
  logic [7:0] rsp_rdata_w;
  logic       mreq_w, mwe_w, mack_w;
  logic [5:0] maddr_w;
  logic [7:0] mwd_w, mrd_w;

  paged_xlate #(.TLB_N(8), .ADDR_W(6), .OFF_W(2), .DATA_W(8)) dut_w (
    .clk(clk), .rst_n(rst_n), .flush(1'b0), .pt_base(6'd48),
    .req_valid(req_valid_w), .req_ready(req_ready_w), .req_we(1'b0),
    .req_addr(req_addr_w), .req_wdata(8'd0),
    .rsp_valid(rsp_valid_w), .rsp_fault(rsp_fault_w), .rsp_paddr(rsp_paddr_w),
    .rsp_rdata(rsp_rdata_w), .mem_req(mreq_w), .mem_we(mwe_w), .mem_addr(maddr_w),
    .mem_wdata(mwd_w), .mem_ack(mack_w), .mem_rdata(mrd_w)
  );

  logic [7:0] mem_w [64];
  int acc_w = 0;
  int histw0 = 0, histw1 = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mack_w <= 1'b0;
    end else begin
      mack_w <= mreq_w && !mack_w;
      if (mreq_w && !mack_w) begin
        mrd_w <= mem_w[maddr_w];
        if (mwe_w) mem_w[maddr_w] <= mwd_w;
        acc_w  <= acc_w + 1;
        histw1 <= histw0;
        histw0 <= int'(maddr_w);
      end
    end
  end

  // ---------------- bench model ----------------
  int sh [256];
  int pt_sh [16];
  int m_tag [8];
  int m_frm [8];
  bit m_vld [8];
  int m_rr = 0;

  function automatic int exp_paddr(int frame, int laddr);
    return frame * 16 + (laddr % 16);
  endfunction

  function automatic int pte_at(int page);
    return (int'(pt_base) + page) % 256;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_pte(input int page, input bit present, input int frame);
    pt_sh[page] = (present ? 128 : 0) + frame;
    mem[pte_at(page)] = 8'(pt_sh[page]);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int i = 0; i < 8; i++) m_vld[i] = 1'b0;
  endtask

  task automatic xact(input bit we, input int a, input int wd);
    int p, hi, fr, nexp, pa, t0, n, vi;
    bit fexp, saw_ready;
    string rq;
    p = a / 16; hi = -1; fr = 0; fexp = 1'b0; saw_ready = 1'b0;
    for (int i = 0; i < 8; i++) if (m_vld[i] && m_tag[i] == p) hi = i;
    if (hi >= 0) begin
      fr = m_frm[hi]; nexp = 1; rq = "R3";
    end else if (pt_sh[p] < 128) begin
      fexp = 1'b1; nexp = 1; rq = "R5";
    end else begin
      fr = pt_sh[p] % 16; nexp = 2; rq = "R4";
      vi = -1;
      for (int i = 7; i >= 0; i--) if (!m_vld[i]) vi = i;
      if (vi < 0) begin vi = m_rr; m_rr = (m_rr + 1) % 8; end
      m_vld[vi] = 1'b1; m_tag[vi] = p; m_frm[vi] = fr;
    end
    pa = fexp ? 0 : exp_paddr(fr, a);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready while idle", int'(req_ready), 1);
    req_valid = 1'b1; req_we = we; req_addr = 8'(a); req_wdata = 8'(wd);
    t0 = acc_total;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 40) begin
      if (req_ready) saw_ready = 1'b1;
      @(negedge clk);
      n++;
    end
    chk(!saw_ready, "R9", "ready low while busy", int'(saw_ready), 0);
    chk(rsp_valid == 1'b1, rq, "response arrives", int'(rsp_valid), 1);
    chk(acc_total - t0 == nexp, rq, "memory access count", acc_total - t0, nexp);
    chk(rsp_fault == fexp, rq, "fault flag", int'(rsp_fault), int'(fexp));
    if (fexp) begin
      chk(hist0 == pte_at(p), "R5", "only access is table read", hist0, pte_at(p));
    end else begin
      chk(int'(rsp_paddr) == pa, "R1", "physical address", int'(rsp_paddr), pa);
      chk(hist0 == pa, rq, "data access address", hist0, pa);
      if (nexp == 2) chk(hist1 == pte_at(p), "R4", "table entry address", hist1, pte_at(p));
      if (we) sh[pa] = wd;
      else chk(int'(rsp_rdata) == sh[pa], "R10", "read data", int'(rsp_rdata), sh[pa]);
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10", "response is one pulse", int'(rsp_valid), 0);
  endtask

  task automatic xact_w(input int a, input int exp_pa, input int exp_acc, input int exp_rd);
    int t0, n;
    @(negedge clk);
    req_valid_w = 1'b1; req_addr_w = 6'(a);
    t0 = acc_w;
    @(negedge clk);
    req_valid_w = 1'b0;
    n = 0;
    while (!rsp_valid_w && n < 40) begin @(negedge clk); n++; end
    chk(rsp_valid_w && !rsp_fault_w, "R2", "word response", int'(rsp_valid_w), 1);
    chk(int'(rsp_paddr_w) == exp_pa, "R2", "word physical address", int'(rsp_paddr_w), exp_pa);
    chk(acc_w - t0 == exp_acc, "R2", "word access count", acc_w - t0, exp_acc);
    chk(int'(rsp_rdata_w) == exp_rd, "R2", "word read data", int'(rsp_rdata_w), exp_rd);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i ^ 8'h5A); sh[i] = i ^ 8'h5A; end
    for (int i = 0; i < 64; i++) mem_w[i] = 8'(i + 3);
    for (int p = 0; p < 16; p++) set_pte(p, 1'b1, p % 14);
    for (int i = 0; i < 8; i++) m_vld[i] = 1'b0;
    mem_w[51] = 8'h89;            // page 3 -> frame 9, present
    mem_w[37] = 8'hC3;

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready in reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R9", "no response in reset", int'(rsp_valid), 0);
    chk(mreq == 1'b0, "R9", "no memory request in reset", int'(mreq), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R4 / R3: page 1 -> frame 6, logical 24 -> 104
    set_pte(1, 1'b1, 6);
    xact(1'b0, 24, 0);
    chk(int'(rsp_paddr) == 104, "R1", "example address 24", int'(rsp_paddr), 104);
    xact(1'b0, 24, 0);                       // R3 hit
    // R3 stale mapping persists until flush
    set_pte(1, 1'b1, 3);
    xact(1'b0, 25, 0);
    chk(int'(rsp_paddr) == 105, "R3", "cached frame still used", int'(rsp_paddr), 105);
    // R7 flush forces a new walk
    do_flush();
    xact(1'b0, 24, 0);
    chk(int'(rsp_paddr) == 56, "R7", "new frame after flush", int'(rsp_paddr), 56);

    // R5 not-present entry, repeated
    set_pte(5, 1'b0, 2);
    xact(1'b0, 8'h55, 0);
    xact(1'b0, 8'h57, 0);

    // R10 write then read back
    xact(1'b1, 24, 8'hA7);
    xact(1'b0, 24, 0);

    // R8 fill all slots, then replace in round-robin order
    do_flush();
    for (int p = 0; p < 16; p++) set_pte(p, 1'b1, (p * 5) % 14);
    for (int p = 0; p < 8; p++) xact(1'b0, p * 16 + 1, 0);
    for (int p = 0; p < 8; p++) xact(1'b0, p * 16 + 2, 0);
    xact(1'b0, 8 * 16, 0);
    xact(1'b0, 9 * 16, 0);
    xact(1'b0, 0, 0);
    xact(1'b0, 2 * 16, 0);

    // R2 word-addressed instance: logical 13 -> physical 37
    xact_w(13, 37, 2, 8'hC3);
    xact_w(13, 37, 1, 8'hC3);
    xact_w(14, 38, 1, 38 + 3);

    // random mix (R1, R3, R4, R5, R6, R7, R8, R10)
    for (int k = 0; k < 400; k++) begin
      r = $urandom % 20;
      if (r == 0) do_flush();
      else if (r < 3) set_pte($urandom % 16, ($urandom % 5) != 0, $urandom % 14);
      else xact(($urandom % 3) == 0, $urandom % 256, $urandom % 256);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule